// File: doc/BRIEF.md
# Daisy-Chain Grayscale Update Sequencer

This block feeds a serial chain of 16-channel, 12-bit PWM driver devices. A host writes per-channel levels through an index/value port into a local channel store. The block serialises the whole chain image on a mode-0 serial clock and data pair. It also generates a free-running grayscale clock and drives the blanking and latch strobes. Each PWM period therefore lasts an exact number of grayscale clocks, 4096 by default.

Two update timings are selected by a static parameter. In the overlapped timing, the next image is shifted while the current period runs, and it is latched during the short blank at the end of that period. In the in-blank timing, every period ends with a stretched blank: the full image is shifted, latched, and then the grayscale clock restarts. After reset the block keeps the outputs blanked, clears the chain with a run of zero bits and a latch, and only then starts cycling. The frame being shifted is a snapshot taken when the shift starts. Writes that arrive during a shift therefore only reach the following frame.

Top module: `gsq_chain_seq`

## Requirements
- R1: While reset is held, blank_o is 1 and xlat_o, sck_o and gsclk_o are 0.
- R2: After reset, blank_o stays 1 while at least 200 x N_CHIPS zero bits are shifted, then one xlat_o pulse loads zeros into every channel; no grayscale clock edge occurs before that pulse.
- R3: A write with wr_idx below 16 x N_CHIPS stores wr_val for that channel. Each frame is 192 x N_CHIPS bits, sent from the highest channel down to channel 0, each level MSB first. For a receiver that shifts sdo_o in at every sck_o rise, channel c therefore lands in bits [12c+11:12c] of the chain.
- R4: A write with wr_idx of 16 x N_CHIPS or above changes no channel and does not change the frame length.
- R5: sck_o idles low; sdo_o changes only while sck_o is low and is stable during every high phase and at every rising edge.
- R6: Between each release of blank_o and the next assertion there are exactly GS_COUNT rising edges of gsclk_o, and gsclk_o never rises while blank_o is 1.
- R7: xlat_o is a one-cycle pulse that occurs only while blank_o is 1 and only when a complete frame (192 x N_CHIPS rising sck_o edges) has finished since the previous pulse.
- R8: With UPD_MODE = UPD_OVERLAP, blank_o stays high for exactly 2 cycles (blank plus latch) when a frame is pending, and there are no sck_o edges while blank_o is high; shifting starts with the new period.
- R9: With UPD_MODE = UPD_IN_BLANK, every blank interval contains one complete frame of 192 x N_CHIPS sck_o rises followed by a latch, even when no data changed, and sck_o never rises while blank_o is 0.
- R10: A write that arrives while a frame is being shifted does not alter that frame; it appears in the frame after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Channel write strobe |
| wr_idx | input | IDX_W | Channel index of the write |
| wr_val | input | 12 | Grayscale level to store |
| sck_o | output | 1 | Serial clock to the chain, idle low |
| sdo_o | output | 1 | Serial data to the chain |
| gsclk_o | output | 1 | Grayscale counting clock |
| blank_o | output | 1 | Blanking strobe, high turns outputs off |
| xlat_o | output | 1 | Latch strobe that moves shifted data to the outputs |

## Verification
The bench attaches a behavioural shift-and-latch receiver to each of two instances, one per update timing. It compares the latched image with values computed from its own copy of the levels. The channel store is swept over all channels with an arithmetic ramp and then with its bitwise complement, which separates bit-order, channel-order and stuck-bit faults. Out-of-range indices are tried at the first invalid index and at the top of the index range, and the frame length is checked to tell an ignored write from an extra shifted field. A write timed into the middle of a running shift separates the snapshot behaviour from a live read of the store. Periods are measured by counting grayscale edges and blank lengths per period, which tells the two update timings apart.

// File: rtl/gsq_pkg.sv
// Shared constants and types for the grayscale chain sequencer.
// Assumes a 12-bit level per channel and 16 channels per chained device.
package gsq_pkg;
    localparam int GS_BITS     = 12;
    localparam int CH_PER_CHIP = 16;

    typedef logic [GS_BITS-1:0] gs_level_t;

    // Selects when the chain image is shifted relative to the PWM period.
    typedef enum logic {
        UPD_OVERLAP  = 1'b0,
        UPD_IN_BLANK = 1'b1
    } upd_mode_e;

    // Sequencer states: power-up clear, active period, end-of-period blank,
    // stretched blank while shifting, and latch pulse.
    typedef enum logic [2:0] {
        ST_INIT  = 3'd0,
        ST_RUN   = 3'd1,
        ST_BLANK = 3'd2,
        ST_FILL  = 3'd3,
        ST_XLAT  = 3'd4
    } seq_state_e;
endpackage

// File: rtl/gsq_frame_store.sv
// Channel level store. One 12-bit register per channel, written by index.
// Indices at or above N_CH match no register and are dropped.
// The whole store is presented as a flat vector with channel c in
// bits [12c+11:12c], so an MSB-first shift sends the highest channel first.
module gsq_frame_store #(
    parameter int N_CH  = 32,
    parameter int IDX_W = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en_i,
    input  logic [IDX_W-1:0]                wr_idx_i,
    input  gsq_pkg::gs_level_t              wr_val_i,
    output logic [N_CH*gsq_pkg::GS_BITS-1:0] frame_o
);
    localparam int LW = gsq_pkg::GS_BITS;

    genvar c;
    generate
        for (c = 0; c < N_CH; c++) begin : g_ch
            gsq_pkg::gs_level_t lvl_q;

            // Hold the level of one channel; update on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lvl_q <= '0;
                end else if (wr_en_i && (wr_idx_i == IDX_W'(c))) begin
                    lvl_q <= wr_val_i;
                end
            end

            assign frame_o[c*LW +: LW] = lvl_q;
        end
    endgenerate

    // An index past the last channel leaves every level untouched.
    assert_oor_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_idx_i >= IDX_W'(N_CH))) |=> $stable(frame_o));
endmodule

// File: rtl/gsq_shifter.sv
// Mode-0 serialiser. On start it snapshots the frame (or zeros) into a
// shift register and sends it MSB first: data is set up while sck is low,
// sck rises (receiver samples), sck falls and the next bit is presented.
// Assumes SCK_HALF >= 1 and INIT_BITS >= FRAME_BITS.
module gsq_shifter #(
    parameter int FRAME_BITS = 384,
    parameter int INIT_BITS  = 400,
    parameter int SCK_HALF   = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  zero_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  sck_o,
    output logic                  sdo_o
);
    localparam int CNT_W = $clog2(INIT_BITS + 1);
    localparam int PH_W  = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    logic [FRAME_BITS-1:0] sr_q;
    logic [CNT_W-1:0]      left_q;
    logic [PH_W-1:0]       ph_q;
    logic                  sck_q;
    logic                  busy_q;
    logic                  done_q;

    // Load, pace and shift the serial frame; flag the last falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            left_q <= '0;
            ph_q   <= '0;
            sck_q  <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i && !busy_q) begin
                sr_q   <= zero_i ? '0 : frame_i;
                left_q <= zero_i ? CNT_W'(INIT_BITS) : CNT_W'(FRAME_BITS);
                ph_q   <= '0;
                sck_q  <= 1'b0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (ph_q == PH_W'(SCK_HALF - 1)) begin
                    ph_q <= '0;
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                    end else begin
                        sck_q  <= 1'b0;
                        sr_q   <= {sr_q[FRAME_BITS-2:0], 1'b0};
                        left_q <= left_q - 1'b1;
                        if (left_q == CNT_W'(1)) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                        end
                    end
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign sck_o  = sck_q;
    assign sdo_o  = sr_q[FRAME_BITS-1];

    // Data must hold while the serial clock is high.
    assert_sdo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> $stable(sdo_o));
    // The serial clock rests low whenever no frame is in flight.
    assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sck_o);
    // Completion is reported once, as the shifter goes idle.
    assert_done_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: rtl/gsq_gsclk_gen.sv
// Grayscale clock generator. While enabled it toggles gsclk every GS_HALF
// system clocks, starting low, and counts rising edges. period_end pulses
// in the last cycle of the high phase of edge number GS_COUNT. Disabling
// clears the counter, so each period restarts at its first edge.
module gsq_gsclk_gen #(
    parameter int GS_HALF  = 1,
    parameter int GS_COUNT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic gsclk_o,
    output logic period_end_o
);
    localparam int PH_W   = (GS_HALF > 1) ? $clog2(GS_HALF) : 1;
    localparam int EDGE_W = $clog2(GS_COUNT + 1);

    logic [PH_W-1:0]   ph_q;
    logic [EDGE_W-1:0] edges_q;
    logic              gs_q;
    logic              ph_last;

    assign ph_last = (ph_q == PH_W'(GS_HALF - 1));

    // Divide the system clock and count grayscale rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            ph_q    <= '0;
            edges_q <= '0;
            gs_q    <= 1'b0;
        end else if (ph_last) begin
            ph_q <= '0;
            gs_q <= !gs_q;
            if (!gs_q) begin
                edges_q <= edges_q + 1'b1;
            end
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    assign gsclk_o      = gs_q;
    assign period_end_o = en_i && gs_q && ph_last && (edges_q == EDGE_W'(GS_COUNT));

    // The edge counter never runs past one period.
    assert_edge_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        edges_q <= EDGE_W'(GS_COUNT));
    // Once disabled the grayscale clock is parked low.
    assert_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !gsclk_o);
endmodule

// File: rtl/gsq_chain_seq.sv
// Grayscale chain sequencer top. It owns the blank/latch state machine and
// ties the channel store, serialiser and grayscale clock together.
// Power-up: blank held, INIT_BITS zero bits, one latch, then cycling.
// UPD_OVERLAP: shift during the period, latch in a 2-cycle end blank.
// UPD_IN_BLANK: every end blank is stretched to shift and latch a frame.
// Assumes the serial frame fits inside one period in overlapped timing.
module gsq_chain_seq #(
    parameter int                 N_CHIPS  = 2,
    parameter int                 GS_HALF  = 1,
    parameter int                 SCK_HALF = 1,
    parameter int                 GS_COUNT = 4096,
    parameter gsq_pkg::upd_mode_e UPD_MODE = gsq_pkg::UPD_OVERLAP,
    localparam int                N_CH     = N_CHIPS * gsq_pkg::CH_PER_CHIP,
    localparam int                IDX_W    = $clog2(N_CH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [11:0]      wr_val,
    output logic             sck_o,
    output logic             sdo_o,
    output logic             gsclk_o,
    output logic             blank_o,
    output logic             xlat_o
);
    import gsq_pkg::*;

    localparam int FRAME_BITS = N_CH * GS_BITS;
    localparam int INIT_BITS  = 200 * N_CHIPS;
    localparam int EDGE_W     = $clog2(GS_COUNT + 1);

    seq_state_e            state_q, state_d;
    logic                  launched_q;
    logic                  pending_q;
    logic                  shift_go, shift_zero;
    logic                  sh_busy, sh_done;
    logic                  gs_en, period_end;
    logic [FRAME_BITS-1:0] frame;

    gsq_frame_store #(.N_CH(N_CH), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_idx_i (wr_idx),
        .wr_val_i (wr_val),
        .frame_o  (frame)
    );

    gsq_shifter #(.FRAME_BITS(FRAME_BITS), .INIT_BITS(INIT_BITS), .SCK_HALF(SCK_HALF)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (shift_go),
        .zero_i  (shift_zero),
        .frame_i (frame),
        .busy_o  (sh_busy),
        .done_o  (sh_done),
        .sck_o   (sck_o),
        .sdo_o   (sdo_o)
    );

    gsq_gsclk_gen #(.GS_HALF(GS_HALF), .GS_COUNT(GS_COUNT)) u_gs (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (gs_en),
        .gsclk_o      (gsclk_o),
        .period_end_o (period_end)
    );

    // Next-state and shift-launch decisions of the blank/latch sequencer.
    always_comb begin
        state_d    = state_q;
        shift_go   = 1'b0;
        shift_zero = 1'b0;
        case (state_q)
            ST_INIT: begin
                if (!launched_q) begin
                    shift_go   = 1'b1;
                    shift_zero = 1'b1;
                end else if (sh_done) begin
                    state_d = ST_XLAT;
                end
            end
            ST_RUN: begin
                if (period_end) state_d = ST_BLANK;
            end
            ST_BLANK: begin
                if (UPD_MODE == UPD_IN_BLANK) begin
                    shift_go = 1'b1;
                    state_d  = ST_FILL;
                end else if (pending_q) begin
                    state_d = ST_XLAT;
                end else begin
                    shift_go = !sh_busy;
                    state_d  = ST_RUN;
                end
            end
            ST_FILL: begin
                if (sh_done) state_d = ST_XLAT;
            end
            ST_XLAT: begin
                state_d = ST_RUN;
                if (UPD_MODE == UPD_OVERLAP) shift_go = !sh_busy;
            end
            default: state_d = ST_INIT;
        endcase
    end

    // State, power-up launch flag and pending-latch flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_INIT;
            launched_q <= 1'b0;
            pending_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_INIT && shift_go) launched_q <= 1'b1;
            if (state_q == ST_XLAT)      pending_q <= 1'b0;
            else if (sh_done)            pending_q <= 1'b1;
        end
    end

    assign gs_en   = (state_q == ST_RUN);
    assign blank_o = (state_q != ST_RUN);
    assign xlat_o  = (state_q == ST_XLAT);

    // Independent count of grayscale rising edges inside the active period.
    logic              gs_prev_q;
    logic              gs_rise;
    logic [EDGE_W-1:0] rise_cnt_q;
    assign gs_rise = gsclk_o && !gs_prev_q;

    // Track grayscale rises per period for the period-length check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gs_prev_q  <= 1'b0;
            rise_cnt_q <= '0;
        end else begin
            gs_prev_q <= gsclk_o;
            if (state_q != ST_RUN) rise_cnt_q <= '0;
            else if (gs_rise)      rise_cnt_q <= rise_cnt_q + 1'b1;
        end
    end

    // A period closes only after exactly GS_COUNT grayscale edges.
    assert_period_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |-> ((rise_cnt_q + EDGE_W'(gs_rise)) == EDGE_W'(GS_COUNT)));
    // The grayscale clock is never high while blanked.
    assert_gs_off_in_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        blank_o |-> !gsclk_o);
    // A latch pulse needs a completed frame behind it.
    assert_latch_needs_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_o |-> pending_q);
    // The latch pulse lasts one cycle.
    assert_latch_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_o |=> !xlat_o);
    // Nothing counts before the power-up clear has been latched.
    assert_init_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT) |-> (!gsclk_o && !xlat_o));

    generate
        if (UPD_MODE == UPD_IN_BLANK) begin : g_inblank_chk
            // In-blank timing: serial activity stays inside the blank.
            assert_shift_in_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
                sh_busy |-> blank_o);
        end else begin : g_overlap_chk
            // Overlapped timing: the blank never spans a shift.
            assert_blank_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == ST_BLANK) |-> !sck_o);
        end
    endgenerate
endmodule

// File: tb/tb_gsq_chain_seq.sv
// Behavioural chain receiver: shifts sdo in on sck rise, copies on xlat,
// and measures periods, blanks and protocol violations. Sampled at negedge.
module tb_chain_rx #(
    parameter int FRAME_BITS = 384
) (
    input  logic                  clk,
    input  logic                  sck,
    input  logic                  sdo,
    input  logic                  xlat,
    input  logic                  blank,
    input  logic                  gsclk,
    output logic [FRAME_BITS-1:0] latched,
    output int                    xlat_cnt,
    output int                    bits_at_latch,
    output int                    ones_seen,
    output int                    gs_last,
    output int                    blank_len_last,
    output int                    sck_blank_last,
    output int                    sck_outside,
    output int                    xlat_bad,
    output int                    gs_bad,
    output int                    sdo_bad
);
    logic [FRAME_BITS-1:0] chain = '0;
    logic sck_p = 1'b0, xlat_p = 1'b0, blank_p = 1'b1, gs_p = 1'b0, sdo_p = 1'b0;
    int bits = 0, gs_run = 0, blank_run = 0, sck_blank_run = 0;

    initial begin
        latched = '0; xlat_cnt = 0; bits_at_latch = 0; ones_seen = 0;
        gs_last = 0; blank_len_last = 0; sck_blank_last = 0; sck_outside = 0;
        xlat_bad = 0; gs_bad = 0; sdo_bad = 0;
    end

    always @(negedge clk) begin
        if (sck === 1'b1 && sdo !== sdo_p) sdo_bad++;
        if (sck === 1'b1 && !sck_p) begin
            chain = {chain[FRAME_BITS-2:0], sdo};
            bits++;
            if (sdo === 1'b1) ones_seen++;
            if (blank === 1'b1) sck_blank_run++; else sck_outside++;
        end
        if (xlat === 1'b1 && !xlat_p) begin
            latched = chain;
            xlat_cnt++;
            bits_at_latch = bits;
            bits = 0;
            if (blank !== 1'b1) xlat_bad++;
        end
        if (gsclk === 1'b1 && !gs_p) begin
            gs_run++;
            if (blank === 1'b1) gs_bad++;
        end
        if (blank === 1'b1) blank_run++;
        if (blank === 1'b1 && !blank_p) begin
            gs_last = gs_run;
            gs_run = 0;
        end
        if (blank === 1'b0 && blank_p) begin
            blank_len_last = blank_run;
            blank_run = 0;
            sck_blank_last = sck_blank_run;
            sck_blank_run = 0;
        end
        sck_p = (sck === 1'b1); xlat_p = (xlat === 1'b1);
        blank_p = (blank !== 1'b0); gs_p = (gsclk === 1'b1); sdo_p = sdo;
    end
endmodule

module tb_gsq_chain_seq;
    localparam int N_CHIPS = 2;
    localparam int N_CH    = N_CHIPS * 16;
    localparam int FB      = N_CH * 12;
    localparam int IDX_W   = $clog2(N_CH) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [11:0] wr_val = '0;
    always #4 clk = ~clk;

    logic sck0, sdo0, gs0, bl0, xl0;
    logic sck1, sdo1, gs1, bl1, xl1;

    gsq_chain_seq #(.N_CHIPS(N_CHIPS), .UPD_MODE(gsq_pkg::UPD_OVERLAP)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
        .sck_o(sck0), .sdo_o(sdo0), .gsclk_o(gs0), .blank_o(bl0), .xlat_o(xl0));

    gsq_chain_seq #(.N_CHIPS(N_CHIPS), .UPD_MODE(gsq_pkg::UPD_IN_BLANK)) dut_alt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
        .sck_o(sck1), .sdo_o(sdo1), .gsclk_o(gs1), .blank_o(bl1), .xlat_o(xl1));

    logic [FB-1:0] lat0, lat1;
    int xc0, bal0, on0, gsl0, bll0, sbl0, sco0, xb0, gb0, sb0;
    int xc1, bal1, on1, gsl1, bll1, sbl1, sco1, xb1, gb1, sb1;

    tb_chain_rx #(.FRAME_BITS(FB)) m0 (.clk(clk), .sck(sck0), .sdo(sdo0), .xlat(xl0),
        .blank(bl0), .gsclk(gs0), .latched(lat0), .xlat_cnt(xc0), .bits_at_latch(bal0),
        .ones_seen(on0), .gs_last(gsl0), .blank_len_last(bll0), .sck_blank_last(sbl0),
        .sck_outside(sco0), .xlat_bad(xb0), .gs_bad(gb0), .sdo_bad(sb0));
    tb_chain_rx #(.FRAME_BITS(FB)) m1 (.clk(clk), .sck(sck1), .sdo(sdo1), .xlat(xl1),
        .blank(bl1), .gsclk(gs1), .latched(lat1), .xlat_cnt(xc1), .bits_at_latch(bal1),
        .ones_seen(on1), .gs_last(gsl1), .blank_len_last(bll1), .sck_blank_last(sbl1),
        .sck_outside(sco1), .xlat_bad(xb1), .gs_bad(gb1), .sdo_bad(sb1));

    int checks = 0, fails = 0;
    logic [11:0] ref_lvl [N_CH];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wr(input int idx, input int val);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_val = 12'(val);
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic wait_both(input int n);
        int t0 = xc0 + n;
        int t1 = xc1 + n;
        while (xc0 < t0 || xc1 < t1) tick(1);
    endtask

    task automatic wait_m0(input int n);
        int t0 = xc0 + n;
        while (xc0 < t0) tick(1);
    endtask

    task automatic cmp_frames(input string req);
        for (int i = 0; i < N_CH; i++) begin
            chk(lat0[i*12 +: 12] == ref_lvl[i], {req, " overlap ch"}, int'(lat0[i*12 +: 12]), int'(ref_lvl[i]));
            chk(lat1[i*12 +: 12] == ref_lvl[i], {req, " inblank ch"}, int'(lat1[i*12 +: 12]), int'(ref_lvl[i]));
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        for (int c = 0; c < 180000; c++) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N_CH; i++) ref_lvl[i] = '0;
        tick(3);
        // R1: reset state of both timings
        chk(bl0 && bl1, "R1 blank", int'(bl0 & bl1), 1);
        chk(!xl0 && !xl1, "R1 xlat", int'(xl0 | xl1), 0);
        chk(!sck0 && !sck1, "R1 sck", int'(sck0 | sck1), 0);
        chk(!gs0 && !gs1, "R1 gsclk", int'(gs0 | gs1), 0);
        rst_n = 1'b1;

        // R2: zero clear of at least 200N bits, then first latch
        wait_both(1);
        chk(bal0 >= 200 * N_CHIPS, "R2 init bits overlap", bal0, 200 * N_CHIPS);
        chk(bal1 >= 200 * N_CHIPS, "R2 init bits inblank", bal1, 200 * N_CHIPS);
        chk(on0 == 0 && on1 == 0, "R2 init ones", on0 + on1, 0);
        chk(gb0 == 0 && gb1 == 0, "R2 gs before latch", gb0 + gb1, 0);
        cmp_frames("R2");

        // R3: ramp pattern over every channel
        for (int i = 0; i < N_CH; i++) begin
            ref_lvl[i] = 12'((i * 291 + 1443) & 4095);
            wr(i, int'(ref_lvl[i]));
        end
        wait_both(2);
        cmp_frames("R3 ramp");
        chk(bal0 == FB, "R7 bits per latch overlap", bal0, FB);
        chk(bal1 == FB, "R7 bits per latch inblank", bal1, FB);
        chk(gsl0 == 4096, "R6 period overlap", gsl0, 4096);
        chk(gsl1 == 4096, "R6 period inblank", gsl1, 4096);
        chk(bll0 == 2, "R8 blank length", bll0, 2);
        chk(sbl0 == 0, "R8 no shift in blank", sbl0, 0);
        chk(sbl1 == FB, "R9 frame in blank", sbl1, FB);
        chk(bll1 >= 2 * FB, "R9 stretched blank", bll1, 2 * FB);

        // R3: complemented pattern
        for (int i = 0; i < N_CH; i++) begin
            ref_lvl[i] = ~ref_lvl[i];
            wr(i, int'(ref_lvl[i]));
        end
        wait_both(2);
        cmp_frames("R3 complement");

        // R4: indices past the last channel
        wr(N_CH, 2748);
        wr(N_CH + 1, 4095);
        wr((1 << IDX_W) - 1, 1365);
        wait_both(2);
        cmp_frames("R4 out of range");
        chk(bal0 == FB, "R4 frame length", bal0, FB);

        // R9: latch every period with unchanged data
        begin
            int x1 = xc1;
            wait_both(1);
            chk(xc1 >= x1 + 1, "R9 latch each period", xc1 - x1, 1);
            chk(sbl1 == FB, "R9 repeat frame", sbl1, FB);
        end

        // R10: write in the middle of a running shift
        wait_m0(1);
        tick(100);
        wr(5, 240);
        wait_m0(1);
        chk(lat0[5*12 +: 12] == ref_lvl[5], "R10 old frame", int'(lat0[5*12 +: 12]), int'(ref_lvl[5]));
        ref_lvl[5] = 12'd240;
        wait_m0(1);
        chk(lat0[5*12 +: 12] == 12'd240, "R10 next frame", int'(lat0[5*12 +: 12]), 240);
        wait_both(2);
        cmp_frames("R10 final");

        // R5, R6, R7, R9: protocol violation counters
        chk(sb0 == 0 && sb1 == 0, "R5 sdo while sck high", sb0 + sb1, 0);
        chk(gb0 == 0 && gb1 == 0, "R6 gs in blank", gb0 + gb1, 0);
        chk(xb0 == 0 && xb1 == 0, "R7 xlat outside blank", xb0 + xb1, 0);
        chk(sco1 == 0, "R9 sck outside blank", sco1, 0);
        chk(gsl0 == 4096 && gsl1 == 4096, "R6 late period", gsl0, 4096);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule